// File: doc/BRIEF.md
# Programmable Sample-Rate Clock Generator

This block produces the timing references for an audio codec core. Four master-clock candidates arrive as single-cycle enable pulses in one synchronous clock domain: a serial bit clock, two crystal references and an external clock. A 3-bit source code picks one of them. A 3-bit rate code picks one of eight fixed divide factors. From the chosen pulse train the block emits two outputs. One is a clock-enable at 256 times the sample rate. The other is a one-cycle sample strobe.

Some sources already run at 256 times the sample rate, so the block passes them straight through. For the crystals and the divided external clock, a fractional accumulator spreads the 256 enables as evenly as it can across each group of factor source pulses. The factors include values that are not powers of two, such as 896, 448 and 2560. A valid flag tells the codec core when the timing can be trusted. It drops on every configuration change and rises again once a settle count has elapsed.

Top module: `sfgen_top`

## Requirements
- R1: In divide mode (source codes 1, 2 and 4), the rate code selects a factor F as follows: 0→3072, 1→1536, 2→896, 3→768, 4→448, 5→384, 6→512, 7→2560. The sample strobe fires on source pulse n, counted from the last restart, exactly when n is a multiple of F.
- R2: In divide mode, source pulse n produces a 256×Fs enable exactly when floor(256·n/F) > floor(256·(n−1)/F). This gives exactly 256 enables in each sample period.
- R3: In bypass mode (source codes 0 and 3), every source pulse produces a 256×Fs enable, and the sample strobe fires on every 256th source pulse.
- R4: Source code 0 takes the bit-clock enable, code 1 the first crystal enable, code 2 the second crystal enable, and codes 3 and 4 the external enable. Pulses on enables that are not selected change neither the outputs nor the count.
- R5: Source codes 5, 6 and 7 are reserved. They hold both strobes and the valid flag low.
- R6: Any change of the source code or the rate code restarts the block. The counters clear, any source pulse in that same cycle is discarded, and in the next cycle the valid flag and both strobes are low.
- R7: For the external sources (codes 3 and 4), the valid flag rises together with the outputs of the 2000th source pulse after a restart and not earlier. It then stays high until the next restart.
- R8: For source codes 0, 1 and 2, the valid flag rises together with the first sample strobe after a restart. It then stays high until the next restart.
- R9: The outputs for a source pulse appear in the clock cycle after that pulse. Each strobe is one cycle wide, and every sample strobe coincides with a 256×Fs enable.
- R10: While reset is held, and in the first cycle after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Master-clock source code |
| rate_sel | input | 3 | Divide-factor code |
| bclk_en | input | 1 | Serial bit-clock pulse |
| xtal_a_en | input | 1 | First crystal pulse |
| xtal_b_en | input | 1 | Second crystal pulse |
| ext_en | input | 1 | External clock pulse |
| fs_tick | output | 1 | One-cycle sample strobe |
| clk256_en | output | 1 | 256×Fs clock-enable |
| clk_valid | output | 1 | Timing settled and trustworthy |

## Verification
The interesting collision is a configuration change arriving in the same cycle as a selected source pulse. The restart must win: the pulse is discarded rather than counted into the new period. The bench provokes this by changing the rate code while the crystal enable is high in that same cycle. It then judges the result in two places. First, the following cycle must show both strobes and the valid flag low. Second, the next sample strobe must land on exactly the F-th later pulse, not the (F−1)-th. Every rate code is swept as well, and each pulse is compared with the floor-division expectation.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

   localparam int FACTOR_W = 12;
   localparam int MAX_FACTOR = 3072;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_BYPASS = 2'd1,
      MODE_DIV    = 2'd2
   } src_mode_t;

   function automatic logic [FACTOR_W-1:0] rate_factor(input logic [2:0] code);
      case (code)
         3'd0:    rate_factor = 12'd3072;
         3'd1:    rate_factor = 12'd1536;
         3'd2:    rate_factor = 12'd896;
         3'd3:    rate_factor = 12'd768;
         3'd4:    rate_factor = 12'd448;
         3'd5:    rate_factor = 12'd384;
         3'd6:    rate_factor = 12'd512;
         default: rate_factor = 12'd2560;
      endcase
   endfunction

   function automatic src_mode_t src_mode(input logic [2:0] code);
      case (code)
         3'd0, 3'd3:       src_mode = MODE_BYPASS;
         3'd1, 3'd2, 3'd4: src_mode = MODE_DIV;
         default:          src_mode = MODE_OFF;
      endcase
   endfunction

endpackage

// File: rtl/sfg_src_sel.sv
module sfg_src_sel (
   input  logic [2:0] src_sel,
   input  logic       bclk_en,
   input  logic       xtal_a_en,
   input  logic       xtal_b_en,
   input  logic       ext_en,
   output logic       pulse_o,
   output logic       is_ext_o
);
   logic [3:0] raw;
   logic [7:0] sel_vec;

   assign raw = {ext_en, xtal_b_en, xtal_a_en, bclk_en};

   for (genvar i = 0; i < 8; i++) begin : g_route
      localparam int IDX = (i < 3) ? i : (i <= 4) ? 3 : -1;
      if (IDX < 0) begin : g_rsv
         assign sel_vec[i] = 1'b0;
      end else begin : g_live
         assign sel_vec[i] = raw[IDX];
      end
   end

   assign pulse_o  = sel_vec[src_sel];
   assign is_ext_o = (src_sel == 3'd3) || (src_sel == 3'd4);

endmodule

// File: rtl/sfg_frac_div.sv
module sfg_frac_div #(
   parameter int OVERSAMPLE = 256,
   parameter int FW         = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          pulse,
   input  logic          bypass,
   input  logic [FW-1:0] factor,
   output logic          en_o,
   output logic          fs_o
);
   localparam int             CW   = $clog2(OVERSAMPLE);
   localparam logic [FW:0]    STEP = (FW+1)'(OVERSAMPLE);
   localparam logic [CW-1:0]  LAST = CW'(OVERSAMPLE - 1);

   logic [FW-1:0] acc;
   logic [FW:0]   sum;
   logic [CW-1:0] cnt;
   logic          hit;

   always_comb begin
      sum = {1'b0, acc} + STEP;
      if (bypass) hit = pulse;
      else        hit = pulse && (sum >= {1'b0, factor});
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         acc  <= '0;
         cnt  <= '0;
         en_o <= 1'b0;
         fs_o <= 1'b0;
      end else begin
         en_o <= hit;
         fs_o <= hit && (cnt == LAST);
         if (hit) cnt <= cnt + 1'b1;
         if (pulse && !bypass)
            acc <= hit ? FW'(sum - {1'b0, factor}) : sum[FW-1:0];
      end
   end

   AST_FS_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      fs_o |-> en_o); // R9

   AST_EN_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      en_o |-> $past(pulse)); // R2

endmodule

// File: rtl/sfg_settle.sv
module sfg_settle #(
   parameter int SW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          active,
   input  logic          pulse,
   input  logic [SW-1:0] target,
   output logic          valid_o
);
   logic [SW-1:0] cnt;
   logic [SW-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      if (pulse && (cnt < target)) cnt_nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt     <= '0;
         valid_o <= 1'b0;
      end else begin
         cnt     <= cnt_nxt;
         valid_o <= active && (cnt_nxt >= target);
      end
   end

   AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !valid_o); // R6

   AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !restart && active) |=> valid_o); // R7

endmodule

// File: rtl/sfgen_top.sv
module sfgen_top #(
   parameter int OVERSAMPLE = 256,
   parameter int EXT_SETTLE = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] src_sel,
   input  logic [2:0] rate_sel,
   input  logic       bclk_en,
   input  logic       xtal_a_en,
   input  logic       xtal_b_en,
   input  logic       ext_en,
   output logic       fs_tick,
   output logic       clk256_en,
   output logic       clk_valid
);
   import sfg_pkg::*;

   localparam int FW   = FACTOR_W;
   localparam int SMAX = (EXT_SETTLE > MAX_FACTOR) ? EXT_SETTLE : MAX_FACTOR;
   localparam int SW   = $clog2(SMAX + 1);

   if ((OVERSAMPLE & (OVERSAMPLE - 1)) != 0 || OVERSAMPLE < 2) begin : g_bad_os
      $error("OVERSAMPLE must be a power of two");
   end
   if (OVERSAMPLE > 384) begin : g_bad_ratio
      $error("OVERSAMPLE must not exceed the smallest divide factor");
   end
   if (EXT_SETTLE < 1) begin : g_bad_settle
      $error("EXT_SETTLE must be positive");
   end

   logic [2:0]    src_q, rate_q;
   logic          restart;
   logic          raw_pulse, is_ext, pulse;
   src_mode_t     mode;
   logic [FW-1:0] factor;
   logic [SW-1:0] target;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         rate_q <= '0;
      end else begin
         src_q  <= src_sel;
         rate_q <= rate_sel;
      end
   end

   assign restart = (src_sel != src_q) || (rate_sel != rate_q);
   assign mode    = src_mode(src_sel);
   assign factor  = rate_factor(rate_sel);
   assign pulse   = raw_pulse && !restart && (mode != MODE_OFF);

   always_comb begin
      if (is_ext)                    target = SW'(EXT_SETTLE);
      else if (mode == MODE_BYPASS)  target = SW'(OVERSAMPLE);
      else                           target = SW'(factor);
   end

   sfg_src_sel u_sel (
      .src_sel   (src_sel),
      .bclk_en   (bclk_en),
      .xtal_a_en (xtal_a_en),
      .xtal_b_en (xtal_b_en),
      .ext_en    (ext_en),
      .pulse_o   (raw_pulse),
      .is_ext_o  (is_ext)
   );

   sfg_frac_div #(.OVERSAMPLE(OVERSAMPLE), .FW(FW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .pulse   (pulse),
      .bypass  (mode == MODE_BYPASS),
      .factor  (factor),
      .en_o    (clk256_en),
      .fs_o    (fs_tick)
   );

   sfg_settle #(.SW(SW)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .active  (mode != MODE_OFF),
      .pulse   (pulse),
      .target  (target),
      .valid_o (clk_valid)
   );

   AST_RSV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel >= 3'd5) |=> (!fs_tick && !clk256_en && !clk_valid)); // R5

endmodule

// File: tb/sfgen_top_tb.sv
module sfgen_top_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] src_sel, rate_sel;
   logic       bclk_en, xtal_a_en, xtal_b_en, ext_en;
   logic       fs_tick, clk256_en, clk_valid;

   always #2 clk = ~clk;

   sfgen_top u_dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .rate_sel(rate_sel),
      .bclk_en(bclk_en), .xtal_a_en(xtal_a_en), .xtal_b_en(xtal_b_en),
      .ext_en(ext_en), .fs_tick(fs_tick), .clk256_en(clk256_en),
      .clk_valid(clk_valid)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int cur_src, cur_rate, n;

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s src=%0d rate=%0d n=%0d got=%0d exp=%0d",
                  req, what, cur_src, cur_rate, n, got, exp);
      end
   endtask

   function automatic int fac(input int r);
      case (r)
         0: return 3072;  1: return 1536;  2: return 896;  3: return 768;
         4: return 448;   5: return 384;   6: return 512;  default: return 2560;
      endcase
   endfunction

   task automatic drive_sel(input logic v);
      case (cur_src)
         0: bclk_en = v;
         1: xtal_a_en = v;
         2: xtal_b_en = v;
         3, 4: ext_en = v;
         default: begin bclk_en = v; xtal_a_en = v; xtal_b_en = v; ext_en = v; end
      endcase
   endtask

   task automatic drive_decoy(input logic v);
      if (cur_src != 0) bclk_en = v;
      if (cur_src != 1) xtal_a_en = v;
      if (cur_src != 2) xtal_b_en = v;
      if (cur_src != 3 && cur_src != 4) ext_en = v;
      if (cur_src > 4) begin bclk_en = 0; xtal_a_en = 0; xtal_b_en = 0; ext_en = 0; end
   endtask

   task automatic set_cfg(input int s, input int r);
      src_sel = 3'(s); rate_sel = 3'(r);
      cur_src = s; cur_rate = r; n = 0;
      @(negedge clk);
      chk("R6", "valid after change", clk_valid, 0);
      chk("R6", "enable after change", clk256_en, 0);
   endtask

   task automatic step();
      bit off, byp, ext;
      int p, e_en, e_fs, e_v;
      off = cur_src > 4;
      byp = (cur_src == 0) || (cur_src == 3);
      ext = (cur_src == 3) || (cur_src == 4);
      p   = byp ? 256 : fac(cur_rate);
      drive_sel(1'b1);
      @(negedge clk);
      drive_sel(1'b0);
      n++;
      e_en = off ? 0 : byp ? 1 : (((256 * n) / p) != ((256 * (n - 1)) / p)) ? 1 : 0;
      e_fs = off ? 0 : ((n % p) == 0) ? 1 : 0;
      e_v  = off ? 0 : (n >= (ext ? 2000 : p)) ? 1 : 0;
      if (off) begin
         chk("R5", "enable", clk256_en, 0);
         chk("R5", "strobe", fs_tick, 0);
         chk("R5", "valid", clk_valid, 0);
      end else begin
         chk(byp ? "R3" : "R2", "enable", clk256_en, e_en);
         chk(byp ? "R3" : "R1", "strobe", fs_tick, e_fs);
         chk(ext ? "R7" : "R8", "valid", clk_valid, e_v);
      end
      drive_decoy(1'b1);
      @(negedge clk);
      drive_decoy(1'b0);
      chk("R4 R9", "enable in decoy cycle", clk256_en, 0);
      chk("R4 R9", "strobe in decoy cycle", fs_tick, 0);
      chk("R4", "valid in decoy cycle", clk_valid, e_v);
   endtask

   task automatic run(input int s, input int r, input int cnt);
      set_cfg(s, r);
      repeat (cnt) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog got=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; src_sel = 3'd1; rate_sel = 3'd0;
      bclk_en = 0; xtal_a_en = 0; xtal_b_en = 0; ext_en = 0;
      cur_src = 1; cur_rate = 0; n = 0;
      repeat (3) @(negedge clk);
      chk("R10", "strobe in reset", fs_tick, 0);
      chk("R10", "valid in reset", clk_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R10", "enable after reset", clk256_en, 0);
      chk("R10", "strobe after reset", fs_tick, 0);
      chk("R10", "valid after reset", clk_valid, 0);

      // divide mode, every rate code on the first crystal
      for (int r = 0; r < 8; r++) run(1, r, fac(r) + 8);
      // second crystal
      run(2, 2, 900);
      run(2, 5, 390);
      // divided external clock: valid waits for 2000 pulses
      run(4, 4, 2010);
      run(4, 7, 2600);
      // bypass sources
      run(0, 3, 520);
      run(3, 1, 2010);
      // reserved source codes
      for (int s = 5; s < 8; s++) run(s, 2, 20);

      // restart colliding with a selected pulse: pulse must be dropped (R6)
      run(1, 5, 100);
      rate_sel = 3'd6;
      xtal_a_en = 1'b1;
      cur_rate = 6;
      @(negedge clk);
      xtal_a_en = 1'b0;
      n = 0;
      chk("R6", "enable after colliding change", clk256_en, 0);
      chk("R6", "strobe after colliding change", fs_tick, 0);
      chk("R6", "valid after colliding change", clk_valid, 0);
      repeat (520) step();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule